// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block watches the write cycles that a byte-wide flash array receives after its strobes have been captured, and recognises the multi-write unlock sequences that ask for a byte program, a sector erase, a whole-array erase, or entry into identification mode. When a sequence completes, it raises a single-cycle start request toward the block that times the operation. Along with that request it holds the target address, and the data byte for a program.

Every command opens with the same pair of unlock writes. Any write that breaks the expected order sends the decoder back to plain read mode, because no dedicated reset command exists. While identification mode is active, a read address is decoded into a manufacturer code, a device code that tells the top-boot and bottom-boot builds apart, or the boot-block lock status. A hardware lock input guards the 16 KB boot block. A program or erase that would touch the boot block while the lock is asserted is dropped without any indication.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset the decoder is in read mode: `id_mode` is 0, all three start outputs are 0 and `id_data` is 00h.
- R2: Unlock writes compare only address bits 14:0 against 5555h and 2AAAh. Bits 17:15 are ignored, so 3D555h acts as 5555h and 3AAAAh acts as 2AAAh.
- R3: The write sequence AAh@5555h, 55h@2AAAh, A0h@5555h, then PD@PA pulses `prog_start` in the clock after the fourth write. During that pulse `op_addr` = PA and `op_data` = PD.
- R4: The write sequence AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h, 55h@2AAAh, then 30h@SA pulses `sect_erase_start`, with `op_addr` = SA. Bits 17:9 of SA select the 512-byte sector.
- R5: The same five writes followed by 10h@5555h pulse `chip_erase_start`.
- R6: A write that does not match the next expected step, such as FFh@5555h, returns the decoder to read mode. The steps written before it are forgotten, so any later writes that would have finished the old sequence start nothing.
- R7: AAh@5555h, 55h@2AAAh, 90h@5555h sets `id_mode` to 1 in the clock after the third write.
- R8: In identification mode, `id_data` is 40h when `rd_addr[1:0]`=0. When `rd_addr[1:0]`=1 it is 02h in the top-boot build and A2h in the bottom-boot build.
- R9: In identification mode, a read with `rd_addr[1:0]`=2 inside the boot block returns 01h if `boot_lock` is 1 and 00h if it is 0. The same offset outside the boot block returns 00h.
- R10: Any accepted write in identification mode clears `id_mode` in the next clock.
- R11: While `boot_lock` is 1, a program or sector erase whose target lies in the boot block is dropped, and so is any chip erase. The boot block spans 3C000h–3FFFFh in the top-boot build and 00000h–03FFFh in the bottom-boot build.
- R12: A write presented while `busy` is 1 is ignored: it neither advances nor aborts a sequence, and it starts nothing.
- R13: At most one start output is high in any cycle, and each start pulse lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | One captured bus write this cycle |
| wr_addr | input | 18 | Address of the captured write |
| wr_data | input | 8 | Data of the captured write |
| busy | input | 1 | Operation in progress; writes are ignored |
| boot_lock | input | 1 | Boot-block protection active |
| rd_addr | input | 18 | Read address for identification decode |
| prog_start | output | 1 | Byte program request pulse |
| sect_erase_start | output | 1 | Sector erase request pulse |
| chip_erase_start | output | 1 | Whole-array erase request pulse |
| op_addr | output | 18 | Target address of the last request |
| op_data | output | 8 | Data byte of the last program request |
| id_mode | output | 1 | Identification mode active |
| id_data | output | 8 | Identification read value |

## Verification
The hardest situation to reach from the ports is a stray write arriving while `busy` is high in the middle of an unlock sequence. If the block were not busy, that write would abort the sequence. The stimulus gives the first two unlock writes, then an FFh@5555h write with `busy` raised, then finishes the program sequence. A start pulse at the end proves the stray write was neither taken as an abort nor as a step. A top-boot and a bottom-boot instance run side by side on the same writes, so the same boot-block target is shown to be dropped in one build and accepted in the other.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

    typedef enum logic [2:0] {
        ST_READ,
        ST_UNL1,
        ST_UNL2,
        ST_PROG,
        ST_ERS_SET,
        ST_ERS_UNL1,
        ST_ERS_UNL2,
        ST_IDENT
    } seq_state_e;

    localparam logic [7:0] CMD_UNLOCK_A = 8'hAA;
    localparam logic [7:0] CMD_UNLOCK_B = 8'h55;
    localparam logic [7:0] CMD_PROGRAM  = 8'hA0;
    localparam logic [7:0] CMD_ERASE    = 8'h80;
    localparam logic [7:0] CMD_IDENT    = 8'h90;
    localparam logic [7:0] CMD_SECTOR   = 8'h30;
    localparam logic [7:0] CMD_CHIP     = 8'h10;

endpackage

// File: rtl/flash_unlock_match.sv
module flash_unlock_match #(
    parameter int ADDR_W = 18,
    parameter int CMP_W  = 15
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit_first,
    output logic              hit_second
);
    localparam logic [CMP_W-1:0] KEY_FIRST  = CMP_W'(15'h5555);
    localparam logic [CMP_W-1:0] KEY_SECOND = CMP_W'(15'h2AAA);

    always_comb begin
        hit_first  = (addr[CMP_W-1:0] == KEY_FIRST);
        hit_second = (addr[CMP_W-1:0] == KEY_SECOND);
    end
endmodule

// File: rtl/flash_boot_region.sv
module flash_boot_region #(
    parameter int ADDR_W     = 18,
    parameter int BOOT_BYTES = 16384,
    parameter bit TOP_BOOT   = 1'b1
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              in_boot
);
    localparam int BOOT_LSB = $clog2(BOOT_BYTES);
    localparam int TAG_W    = ADDR_W - BOOT_LSB;

    generate
        if (TOP_BOOT) begin : g_top
            assign in_boot = &addr[ADDR_W-1:BOOT_LSB];
        end else begin : g_bottom
            assign in_boot = (addr[ADDR_W-1:BOOT_LSB] == {TAG_W{1'b0}});
        end
    endgenerate
endmodule

// File: rtl/flash_id_mux.sv
module flash_id_mux #(
    parameter int         ADDR_W   = 18,
    parameter int         DATA_W   = 8,
    parameter bit         TOP_BOOT = 1'b1,
    parameter logic [7:0] MFR_CODE = 8'h40,
    parameter logic [7:0] TOP_CODE = 8'h02,
    parameter logic [7:0] BOT_CODE = 8'hA2
) (
    input  logic              enable,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_in_boot,
    input  logic              lock,
    output logic [DATA_W-1:0] data
);
    localparam logic [DATA_W-1:0] DEV_CODE = TOP_BOOT ? DATA_W'(TOP_CODE) : DATA_W'(BOT_CODE);

    always_comb begin
        data = '0;
        if (enable) begin
            unique case (rd_addr[1:0])
                2'd0:    data = DATA_W'(MFR_CODE);
                2'd1:    data = DEV_CODE;
                2'd2:    data = DATA_W'(rd_in_boot & lock);
                default: data = '0;
            endcase
        end
    end
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W     = 18,
    parameter int DATA_W     = 8,
    parameter int CMP_W      = 15,
    parameter int BOOT_BYTES = 16384,
    parameter bit TOP_BOOT   = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              busy,
    input  logic              boot_lock,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              prog_start,
    output logic              sect_erase_start,
    output logic              chip_erase_start,
    output logic [ADDR_W-1:0] op_addr,
    output logic [DATA_W-1:0] op_data,
    output logic              id_mode,
    output logic [DATA_W-1:0] id_data
);
    typedef struct packed {
        seq_state_e        st;
        logic              prog;
        logic              sect;
        logic              chip;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } seq_regs_t;

    seq_regs_t r_q, r_d;

    logic hit_a, hit_b, wr_in_boot, rd_in_boot, op_in_boot;
    logic take;

    flash_unlock_match #(.ADDR_W(ADDR_W), .CMP_W(CMP_W)) u_match (
        .addr(wr_addr), .hit_first(hit_a), .hit_second(hit_b)
    );

    flash_boot_region #(.ADDR_W(ADDR_W), .BOOT_BYTES(BOOT_BYTES), .TOP_BOOT(TOP_BOOT)) u_wr_boot (
        .addr(wr_addr), .in_boot(wr_in_boot)
    );

    flash_boot_region #(.ADDR_W(ADDR_W), .BOOT_BYTES(BOOT_BYTES), .TOP_BOOT(TOP_BOOT)) u_rd_boot (
        .addr(rd_addr), .in_boot(rd_in_boot)
    );

    flash_boot_region #(.ADDR_W(ADDR_W), .BOOT_BYTES(BOOT_BYTES), .TOP_BOOT(TOP_BOOT)) u_op_boot (
        .addr(r_q.addr), .in_boot(op_in_boot)
    );

    flash_id_mux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .TOP_BOOT(TOP_BOOT)) u_id (
        .enable(r_q.st == ST_IDENT), .rd_addr(rd_addr), .rd_in_boot(rd_in_boot),
        .lock(boot_lock), .data(id_data)
    );

    assign take = wr_valid & ~busy;

    always_comb begin
        r_d      = r_q;
        r_d.prog = 1'b0;
        r_d.sect = 1'b0;
        r_d.chip = 1'b0;
        if (take) begin
            r_d.st = ST_READ;
            unique case (r_q.st)
                ST_READ, ST_IDENT: begin
                    if (hit_a && wr_data == DATA_W'(CMD_UNLOCK_A)) r_d.st = ST_UNL1;
                end
                ST_UNL1: begin
                    if (hit_b && wr_data == DATA_W'(CMD_UNLOCK_B)) r_d.st = ST_UNL2;
                end
                ST_UNL2: begin
                    if (hit_a) begin
                        if (wr_data == DATA_W'(CMD_PROGRAM))    r_d.st = ST_PROG;
                        else if (wr_data == DATA_W'(CMD_ERASE)) r_d.st = ST_ERS_SET;
                        else if (wr_data == DATA_W'(CMD_IDENT)) r_d.st = ST_IDENT;
                    end
                end
                ST_PROG: begin
                    if (!(boot_lock && wr_in_boot)) begin
                        r_d.prog = 1'b1;
                        r_d.addr = wr_addr;
                        r_d.data = wr_data;
                    end
                end
                ST_ERS_SET: begin
                    if (hit_a && wr_data == DATA_W'(CMD_UNLOCK_A)) r_d.st = ST_ERS_UNL1;
                end
                ST_ERS_UNL1: begin
                    if (hit_b && wr_data == DATA_W'(CMD_UNLOCK_B)) r_d.st = ST_ERS_UNL2;
                end
                ST_ERS_UNL2: begin
                    if (wr_data == DATA_W'(CMD_SECTOR)) begin
                        if (!(boot_lock && wr_in_boot)) begin
                            r_d.sect = 1'b1;
                            r_d.addr = wr_addr;
                        end
                    end else if (hit_a && wr_data == DATA_W'(CMD_CHIP) && !boot_lock) begin
                        r_d.chip = 1'b1;
                    end
                end
                default: r_d.st = ST_READ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{st: ST_READ, prog: 1'b0, sect: 1'b0, chip: 1'b0, addr: '0, data: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign prog_start       = r_q.prog;
    assign sect_erase_start = r_q.sect;
    assign chip_erase_start = r_q.chip;
    assign op_addr          = r_q.addr;
    assign op_data          = r_q.data;
    assign id_mode          = (r_q.st == ST_IDENT);

    AST_ONE_START: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({prog_start, sect_erase_start, chip_erase_start})); // R13
    AST_PULSE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_start | sect_erase_start | chip_erase_start) |=> !(prog_start | sect_erase_start | chip_erase_start)); // R13
    AST_BUSY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !(prog_start | sect_erase_start | chip_erase_start)); // R12
    AST_ID_LEAVE: assert property (@(posedge clk) disable iff (!rst_n)
        (id_mode && wr_valid && !busy) |=> !id_mode); // R10
    AST_BOOT_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_start | sect_erase_start) |-> !($past(boot_lock) && op_in_boot)); // R11
    AST_CHIP_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
        chip_erase_start |-> !$past(boot_lock)); // R11
endmodule

// File: tb/flash_cmd_seq_tb.sv
module flash_cmd_seq_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_valid = 1'b0;
    logic [17:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        busy = 1'b0;
    logic        boot_lock = 1'b0;
    logic [17:0] rd_addr = '0;

    logic        t_prog, t_sect, t_chip, t_id;
    logic [17:0] t_addr;
    logic [7:0]  t_data, t_idd;
    logic        b_prog, b_sect, b_chip, b_id;
    logic [17:0] b_addr;
    logic [7:0]  b_data, b_idd;

    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    flash_cmd_seq #(.TOP_BOOT(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
        .busy(busy), .boot_lock(boot_lock), .rd_addr(rd_addr),
        .prog_start(t_prog), .sect_erase_start(t_sect), .chip_erase_start(t_chip),
        .op_addr(t_addr), .op_data(t_data), .id_mode(t_id), .id_data(t_idd)
    );

    flash_cmd_seq #(.TOP_BOOT(1'b0)) u_bot (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
        .busy(busy), .boot_lock(boot_lock), .rd_addr(rd_addr),
        .prog_start(b_prog), .sect_erase_start(b_sect), .chip_erase_start(b_chip),
        .op_addr(b_addr), .op_data(b_data), .id_mode(b_id), .id_data(b_idd)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [17:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_valid = 1'b1;
        wr_addr  = a;
        wr_data  = d;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic unlock();
        wr(18'h05555, 8'hAA);
        wr(18'h02AAA, 8'h55);
    endtask

    task automatic erase_prefix();
        unlock();
        wr(18'h05555, 8'h80);
        unlock();
    endtask

    task automatic t_reset();
        check("R1 prog", {29'd0, t_prog, t_sect, t_chip}, 0);
        check("R1 id_mode", t_id, 0);
        check("R1 id_data", t_idd, 0);
    endtask

    task automatic t_program();
        unlock();
        wr(18'h05555, 8'hA0);
        check("R3 no early pulse", t_prog, 0);
        wr(18'h01234, 8'h5A);
        check("R3 prog_start", t_prog, 1);
        check("R3 op_addr", t_addr, 18'h01234);
        check("R3 op_data", t_data, 8'h5A);
        check("R13 onehot", {t_sect, t_chip}, 0);
        @(negedge clk);
        check("R13 pulse width", t_prog, 0);
    endtask

    task automatic t_upper_bits();
        wr(18'h3D555, 8'hAA);
        wr(18'h3AAAA, 8'h55);
        wr(18'h25555, 8'hA0);
        wr(18'h00456, 8'hC3);
        check("R2 alias prog", t_prog, 1);
        check("R2 alias data", t_data, 8'hC3);
    endtask

    task automatic t_sector();
        erase_prefix();
        wr(18'h12345, 8'h30);
        check("R4 sect_erase_start", t_sect, 1);
        check("R4 op_addr", t_addr, 18'h12345);
        check("R13 onehot sect", {t_prog, t_chip}, 0);
        @(negedge clk);
        check("R13 sect width", t_sect, 0);
    endtask

    task automatic t_chip_erase();
        erase_prefix();
        wr(18'h05555, 8'h10);
        check("R5 chip_erase_start", t_chip, 1);
        check("R5 no sect", t_sect, 0);
    endtask

    task automatic t_abort();
        wr(18'h05555, 8'hAA);
        wr(18'h05555, 8'hFF);
        wr(18'h05555, 8'hA0);
        wr(18'h00100, 8'h11);
        check("R6 abort unlock", t_prog, 0);
        erase_prefix();
        wr(18'h05555, 8'hFF);
        wr(18'h05555, 8'h10);
        check("R6 abort erase", {t_sect, t_chip}, 0);
        check("R6 back to read", t_id, 0);
        unlock();
        wr(18'h05555, 8'hA0);
        wr(18'h00200, 8'h22);
        check("R6 recovers", t_prog, 1);
    endtask

    task automatic t_ident();
        unlock();
        check("R7 not yet", t_id, 0);
        wr(18'h05555, 8'h90);
        check("R7 id_mode", t_id, 1);
        check("R7 id_mode bottom", b_id, 1);
        rd_addr = 18'h00000; #1;
        check("R8 mfr", t_idd, 8'h40);
        rd_addr = 18'h00001; #1;
        check("R8 dev top", t_idd, 8'h02);
        check("R8 dev bottom", b_idd, 8'hA2);
        boot_lock = 1'b1;
        rd_addr = 18'h3C002; #1;
        check("R9 top locked", t_idd, 8'h01);
        check("R9 bottom outside", b_idd, 8'h00);
        rd_addr = 18'h00002; #1;
        check("R9 bottom locked", b_idd, 8'h01);
        check("R9 top outside", t_idd, 8'h00);
        boot_lock = 1'b0;
        rd_addr = 18'h3C002; #1;
        check("R9 top unlocked", t_idd, 8'h00);
        wr(18'h00000, 8'hF0);
        check("R10 id exit", t_id, 0);
        rd_addr = 18'h00000; #1;
        check("R10 id_data cleared", t_idd, 8'h00);
    endtask

    task automatic t_protect();
        boot_lock = 1'b1;
        unlock();
        wr(18'h05555, 8'hA0);
        wr(18'h3C100, 8'h33);
        check("R11 top drop prog", t_prog, 0);
        check("R11 bottom takes high", b_prog, 1);
        unlock();
        wr(18'h05555, 8'hA0);
        wr(18'h00100, 8'h44);
        check("R11 top takes low", t_prog, 1);
        check("R11 bottom drop prog", b_prog, 0);
        erase_prefix();
        wr(18'h3E000, 8'h30);
        check("R11 top drop sect", t_sect, 0);
        erase_prefix();
        wr(18'h05555, 8'h10);
        check("R11 drop chip", {t_chip, b_chip}, 0);
        boot_lock = 1'b0;
        unlock();
        wr(18'h05555, 8'hA0);
        wr(18'h3C100, 8'h55);
        check("R11 unlocked prog", t_prog, 1);
    endtask

    task automatic t_busy();
        unlock();
        busy = 1'b1;
        wr(18'h05555, 8'hFF);
        busy = 1'b0;
        wr(18'h05555, 8'hA0);
        busy = 1'b1;
        wr(18'h00300, 8'h66);
        check("R12 busy no start", t_prog, 0);
        busy = 1'b0;
        wr(18'h00300, 8'h77);
        check("R12 sequence kept", t_prog, 1);
        check("R12 data", t_data, 8'h77);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_program();
        t_upper_bits();
        t_sector();
        t_chip_erase();
        t_abort();
        t_ident();
        t_protect();
        t_busy();
        repeat (2) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule